// File: doc/BRIEF.md
# Microwire Serial EEPROM Slave

This block is a 64-word by 16-bit serial EEPROM model that sits behind three host-driven lines: a chip select, a serial clock and a data-in line. It answers on a single data-out line. The host bit-bangs the lines. The block samples them with the system clock and acts on each rising edge of the serial clock while chip select is high.

Each access starts with a chip-select rising edge. The host then sends a start bit of 1 and an 8-bit command, most significant bit first. The command can read one word, write one word, fill the whole array with one word, or set or clear a write-enable latch. A read returns 16 bits, most significant bit first. The block then waits for a new start bit without needing chip select to be cycled, and it does not advance to the next address. After a single-word write, the block ignores the serial clock until chip select is cycled. The storage is a register array that is loaded with fixed default words at reset.

Top module: `mwire_eeprom`

## Requirements
- R1: During reset and after it, the array holds word 0 = 0x8129, word 1 = 0x10EC, word 2 = 0x8139, word 7 = 0x1400, word 8 = 0x122A and word 9 = 0x1413, with every other word zero. The write-enable latch is clear, the block is idle and data-out is 0.
- R2: A rising edge of chip select clears the bit counter, the input shift register, the output register and data-out, and puts the block in the wait-for-start-bit state. This happens whatever access was in progress.
- R3: The lines are acted on only at a rising edge of the serial clock while chip select is high. Clock edges while chip select is low change nothing, and data-out reads 0 whenever chip select is low.
- R4: In the wait-for-start state, a clock edge with data-in at 1 starts command capture. A clock edge with data-in at 0 leaves the block waiting.
- R5: The command is 8 bits, MSB first; bits 7:6 are the opcode: 10 is read, 01 is write and 00 is extended, and bits 5:0 are the address. For an extended command, bits 5:4 select the operation: 11 is write-enable, 01 is fill-all and 00 is write-disable. After any extended command other than fill-all, and after opcode 11, the block goes idle.
- R6: A read command loads the addressed word and clears data-out. On each of the next 16 serial clock edges, data-out presents the next bit of the word, MSB first.
- R7: After the 16th read clock the block waits for a new start bit. A further command can follow without cycling chip select, and no address auto-increment takes place.
- R8: A write command takes 16 data bits, MSB first, and stores them at the command's address. The block then ignores all serial clock edges until chip select rises again.
- R9: A fill-all command takes 16 data bits and stores them in every word. The block then waits for a start bit without needing chip select to be cycled.
- R10: Write-enable sets the write-enable latch and write-disable clears it. Write and fill-all change the array only while the latch is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; the serial lines are sampled on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| selIn | input | 1 | Chip select from the host, active high |
| sclkIn | input | 1 | Serial clock from the host |
| dinIn | input | 1 | Serial data from the host |
| doutOut | output | 1 | Serial data to the host; 0 while chip select is low |

## Verification
A serial clock rising edge is detected in the system clock cycle in which the bench raises the line, so every state change and every new data-out bit appears after exactly one system clock edge. The bench holds each serial clock phase for two system clocks. It drives the lines and samples data-out on falling system clock edges, after the second high cycle, and so reads a bit only once it has settled. Chip select is also combined directly into data-out, so the quiet value is checked in the same cycle in which chip select falls. Results held in storage are checked only through later serial reads, one word of 16 clock edges at a time, against a model array kept in the bench.

// File: rtl/mwire_eeprom_pkg.sv
package mwire_eeprom_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_CMD,
    ST_READ,
    ST_WRITE,
    ST_FILL
  } eeState_t;

  typedef struct packed {
    logic clearRegs;
    logic shiftIn;
    logic loadRead;
    logic shiftOut;
    logic latchAddr;
    logic commitOne;
    logic commitAll;
    logic setWel;
    logic clrWel;
  } eeStrobe_t;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  localparam logic [1:0] EXT_WDIS = 2'b00;
  localparam logic [1:0] EXT_FILL = 2'b01;
  localparam logic [1:0] EXT_WEN  = 2'b11;

endpackage

// File: rtl/mwire_eeprom_ctrl.sv
module mwire_eeprom_ctrl
  import mwire_eeprom_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CMD_W  = 8,
  parameter int CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csRise,
  input  logic             bitEdge,
  input  logic             dinBit,
  input  logic [3:0]       cmdCode,
  output eeState_t         state,
  output logic [CNT_W-1:0] bitCnt,
  output eeStrobe_t        strobe
);

  localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
  localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

  eeState_t         stateNext;
  logic [CNT_W-1:0] cntNext;
  logic [1:0]       opCode;
  logic [1:0]       extCode;

  assign opCode  = cmdCode[3:2];
  assign extCode = cmdCode[1:0];

  always_comb begin
    stateNext = state;
    cntNext   = bitCnt;
    strobe    = '0;
    if (csRise) begin
      strobe.clearRegs = 1'b1;
      stateNext        = ST_WAIT;
      cntNext          = '0;
    end else if (bitEdge) begin
      unique case (state)
        ST_WAIT: begin
          if (dinBit) begin
            stateNext = ST_CMD;
            cntNext   = '0;
          end
        end
        ST_CMD: begin
          strobe.shiftIn = 1'b1;
          cntNext        = bitCnt + 1'b1;
          if (bitCnt == CMD_LAST) begin
            cntNext = '0;
            unique case (opCode)
              OP_READ: begin
                strobe.loadRead  = 1'b1;
                strobe.latchAddr = 1'b1;
                stateNext        = ST_READ;
              end
              OP_WRITE: begin
                strobe.latchAddr = 1'b1;
                stateNext        = ST_WRITE;
              end
              OP_EXT: begin
                stateNext = ST_IDLE;
                unique case (extCode)
                  EXT_WEN:  strobe.setWel = 1'b1;
                  EXT_WDIS: strobe.clrWel = 1'b1;
                  EXT_FILL: stateNext     = ST_FILL;
                  default:  stateNext     = ST_IDLE;
                endcase
              end
              default: stateNext = ST_IDLE;
            endcase
          end
        end
        ST_READ: begin
          strobe.shiftOut = 1'b1;
          cntNext         = bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            cntNext   = '0;
            stateNext = ST_WAIT;
          end
        end
        ST_WRITE: begin
          strobe.shiftIn = 1'b1;
          cntNext        = bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            strobe.commitOne = 1'b1;
            cntNext          = '0;
            stateNext        = ST_IDLE;
          end
        end
        ST_FILL: begin
          strobe.shiftIn = 1'b1;
          cntNext        = bitCnt + 1'b1;
          if (bitCnt == DATA_LAST) begin
            strobe.commitAll = 1'b1;
            cntNext          = '0;
            stateNext        = ST_WAIT;
          end
        end
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      state  <= stateNext;
      bitCnt <= cntNext;
    end
  end

endmodule

// File: rtl/mwire_eeprom_dp.sv
module mwire_eeprom_dp
  import mwire_eeprom_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 16,
  parameter int          DEPTH    = 64,
  parameter int          CMD_W    = 8,
  parameter logic [15:0] ID_WORD0 = 16'h8129,
  parameter logic [15:0] ID_WORD1 = 16'h10EC,
  parameter logic [15:0] ID_WORD2 = 16'h8139,
  parameter logic [47:0] STATION  = 48'h1413_122A_1400
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          dinBit,
  input  eeStrobe_t                     strobe,
  output logic [3:0]                    cmdCode,
  output logic                          doBit,
  output logic                          wel,
  output logic [DATA_W-1:0]             inShift,
  output logic [DEPTH-1:0][DATA_W-1:0]  memArr
);

  logic [DATA_W-1:0] shiftNext;
  logic [DATA_W-1:0] outReg;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] cmdAddr;
  logic [DEPTH-1:0]  wordWe;

  function automatic logic [DATA_W-1:0] initWord(input int idx);
    case (idx)
      0:       return DATA_W'(ID_WORD0);
      1:       return DATA_W'(ID_WORD1);
      2:       return DATA_W'(ID_WORD2);
      7:       return DATA_W'(STATION[15:0]);
      8:       return DATA_W'(STATION[31:16]);
      9:       return DATA_W'(STATION[47:32]);
      default: return '0;
    endcase
  endfunction

  assign shiftNext = {inShift[DATA_W-2:0], dinBit};
  assign cmdAddr   = shiftNext[ADDR_W-1:0];
  assign cmdCode   = {shiftNext[CMD_W-1 -: 2], shiftNext[ADDR_W-1 -: 2]};

  for (genvar w = 0; w < DEPTH; w++) begin : g_we
    assign wordWe[w] = wel & (strobe.commitAll |
                              (strobe.commitOne & (addrQ == ADDR_W'(w))));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inShift <= '0;
      outReg  <= '0;
      doBit   <= 1'b0;
      addrQ   <= '0;
      wel     <= 1'b0;
    end else begin
      if (strobe.clearRegs) begin
        inShift <= '0;
        outReg  <= '0;
        doBit   <= 1'b0;
      end else begin
        if (strobe.shiftIn) inShift <= shiftNext;
        if (strobe.loadRead) begin
          outReg <= memArr[cmdAddr];
          doBit  <= 1'b0;
        end else if (strobe.shiftOut) begin
          doBit  <= outReg[DATA_W-1];
          outReg <= {outReg[DATA_W-2:0], 1'b0};
        end
      end
      if (strobe.latchAddr) addrQ <= cmdAddr;
      if (strobe.setWel) wel <= 1'b1;
      else if (strobe.clrWel) wel <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) memArr[i] <= initWord(i);
      else if (wordWe[i]) memArr[i] <= shiftNext;
    end
  end

endmodule

// File: rtl/mwire_eeprom.sv
module mwire_eeprom
  import mwire_eeprom_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] ID_WORD0 = 16'h8129,
  parameter logic [15:0] ID_WORD1 = 16'h10EC,
  parameter logic [15:0] ID_WORD2 = 16'h8139,
  parameter logic [47:0] STATION  = 48'h1413_122A_1400
) (
  input  logic clk,
  input  logic rstN,
  input  logic selIn,
  input  logic sclkIn,
  input  logic dinIn,
  output logic doutOut
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int CMD_W = ADDR_W + 2;
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic                         csQ;
  logic                         skQ;
  logic                         csRise;
  logic                         bitEdge;
  logic                         doBit;
  logic                         wel;
  logic [3:0]                   cmdCode;
  logic [CNT_W-1:0]             bitCnt;
  logic [DATA_W-1:0]            inShift;
  logic [DEPTH-1:0][DATA_W-1:0] memArr;
  eeState_t                     state;
  eeStrobe_t                    strobe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csQ <= 1'b0;
      skQ <= 1'b0;
    end else begin
      csQ <= selIn;
      skQ <= sclkIn;
    end
  end

  assign csRise  = selIn & ~csQ;
  assign bitEdge = selIn & sclkIn & ~skQ & ~csRise;
  assign doutOut = selIn & doBit;

  mwire_eeprom_ctrl #(
    .DATA_W(DATA_W), .CMD_W(CMD_W), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csRise(csRise), .bitEdge(bitEdge),
    .dinBit(dinIn), .cmdCode(cmdCode), .state(state),
    .bitCnt(bitCnt), .strobe(strobe)
  );

  mwire_eeprom_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CMD_W(CMD_W),
    .ID_WORD0(ID_WORD0), .ID_WORD1(ID_WORD1), .ID_WORD2(ID_WORD2),
    .STATION(STATION)
  ) dp_i (
    .clk(clk), .rstN(rstN), .dinBit(dinIn), .strobe(strobe),
    .cmdCode(cmdCode), .doBit(doBit), .wel(wel),
    .inShift(inShift), .memArr(memArr)
  );

endmodule

// File: rtl/mwire_eeprom_chk.sv
module mwire_eeprom_chk
  import mwire_eeprom_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 64,
  parameter int CNT_W  = 5
) (
  input logic                         clk,
  input logic                         rstN,
  input logic                         selIn,
  input logic                         sclkIn,
  input logic                         dinIn,
  input eeState_t                     state,
  input logic [CNT_W-1:0]             bitCnt,
  input logic [DATA_W-1:0]            inShift,
  input logic                         wel,
  input logic [DEPTH-1:0][DATA_W-1:0] memArr
);

  logic csPrev;
  logic skPrev;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csPrev <= 1'b0;
      skPrev <= 1'b0;
    end else begin
      csPrev <= selIn;
      skPrev <= sclkIn;
    end
  end

  AST_CS_RISE_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    (selIn && !csPrev) |=> (state == ST_WAIT && bitCnt == '0 && inShift == '0)); // R2

  AST_CS_LOW_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !selIn |=> ($stable(inShift) && $stable(bitCnt) && $stable(state))); // R3

  AST_START_ZERO_WAITS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && selIn && csPrev && sclkIn && !skPrev && !dinIn)
      |=> state == ST_WAIT); // R4

  AST_READ_RETURNS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && bitCnt == CNT_W'(DATA_W - 1) && selIn && csPrev
     && sclkIn && !skPrev) |=> state == ST_WAIT); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && !(selIn && !csPrev)) |=> state == ST_IDLE); // R8

  AST_WEL_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    !wel |=> $stable(memArr)); // R10

endmodule

bind mwire_eeprom mwire_eeprom_chk #(
  .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn), .dinIn(dinIn),
  .state(state), .bitCnt(bitCnt), .inShift(inShift), .wel(wel),
  .memArr(memArr)
);

// File: tb/mwire_eeprom_tb_top.sv
`timescale 1ns/1ps
module mwire_eeprom_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selIn = 1'b0;
  logic sclkIn = 1'b0;
  logic dinIn = 1'b0;
  logic doutOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [15:0] model [64];
  bit          modelWel;

  always #2.5 clk = ~clk;

  mwire_eeprom dut_i (
    .clk(clk), .rstN(rstN), .selIn(selIn), .sclkIn(sclkIn),
    .dinIn(dinIn), .doutOut(doutOut)
  );

  function automatic logic [15:0] expectInit(input int a);
    if (a == 0) return 16'h8129;
    if (a == 1) return 16'h10EC;
    if (a == 2) return 16'h8139;
    if (a == 7) return 16'h1400;
    if (a == 8) return 16'h122A;
    if (a == 9) return 16'h1413;
    return 16'h0000;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sendBit(input logic b, output logic d);
    dinIn  = b;
    sclkIn = 1'b0;
    tick(2);
    sclkIn = 1'b1;
    tick(2);
    d      = doutOut;
    sclkIn = 1'b0;
  endtask

  task automatic csCycle();
    selIn  = 1'b0;
    sclkIn = 1'b0;
    tick(2);
    selIn = 1'b1;
    tick(2);
  endtask

  task automatic sendCmd(input logic [1:0] op, input logic [5:0] a);
    logic       d;
    logic [7:0] c;
    c = {op, a};
    sendBit(1'b1, d);
    for (int i = 7; i >= 0; i--) sendBit(c[i], d);
  endtask

  task automatic shiftData(input logic [15:0] w, output logic [15:0] got);
    logic d;
    for (int i = 15; i >= 0; i--) begin
      sendBit(w[i], d);
      got[i] = d;
    end
  endtask

  task automatic readWord(input logic [5:0] a, input bit cycle,
                          output logic [15:0] w);
    if (cycle) csCycle();
    sendCmd(2'b10, a);
    shiftData(16'h0000, w);
  endtask

  task automatic writeWord(input logic [5:0] a, input logic [15:0] w);
    logic [15:0] g;
    csCycle();
    sendCmd(2'b01, a);
    shiftData(w, g);
    if (modelWel) model[a] = w;
  endtask

  task automatic extCmd(input logic [1:0] code);
    csCycle();
    sendCmd(2'b00, {code, 4'b0000});
    if (code == 2'b11) modelWel = 1'b1;
    if (code == 2'b00) modelWel = 1'b0;
  endtask

  initial begin
    logic [15:0] w;
    logic        d;
    void'($urandom(32'd2024));
    for (int i = 0; i < 64; i++) model[i] = expectInit(i);
    modelWel = 1'b0;
    tick(4);
    check("R1 dout in reset", {15'd0, doutOut}, 16'h0000);
    rstN = 1'b1;
    tick(2);
    check("R1 dout after reset", {15'd0, doutOut}, 16'h0000);

    // R1 default contents
    foreach (model[i]) begin
      if (i < 11 || i == 63) begin
        readWord(6'(i), 1'b1, w);
        check("R1 default word", w, expectInit(i));
      end
    end

    // R10 latch clear after reset: write ignored
    writeWord(6'd5, 16'hBEEF);
    readWord(6'd5, 1'b1, w);
    check("R10 write without enable", w, 16'h0000);

    // R10 enable then write, R5/R8 write stores
    extCmd(2'b11);
    writeWord(6'd5, 16'hBEEF);
    // R8 idle after write: further clocks ignored, dout stays low
    sendCmd(2'b10, 6'd5);
    shiftData(16'hFFFF, w);
    check("R8 ignored after write", w, 16'h0000);
    readWord(6'd5, 1'b1, w);
    check("R8 write stored", w, 16'hBEEF);
    readWord(6'd1, 1'b1, w);
    check("R8 neighbour untouched", w, 16'h10EC);

    // R6/R7 back to back reads without cs, LSB of first word is 1
    readWord(6'd0, 1'b1, w);
    check("R6 read word 0", w, 16'h8129);
    sendCmd(2'b10, 6'd2);
    check("R6 dout cleared at read load", {15'd0, doutOut}, 16'h0000);
    shiftData(16'h0000, w);
    check("R7 second read no cs", w, 16'h8139);
    // R7 zero bits keep waiting; no auto increment
    for (int i = 0; i < 5; i++) sendBit(1'b0, d);
    readWord(6'd7, 1'b0, w);
    check("R7 waits then new read", w, 16'h1400);

    // R3 dout low when cs low after a read ending in 1
    readWord(6'd9, 1'b1, w);
    check("R3 read word 9", w, 16'h1413);
    selIn = 1'b0;
    tick(1);
    check("R3 dout low with cs low", {15'd0, doutOut}, 16'h0000);
    // R3 clock edges with cs low are ignored
    for (int i = 0; i < 12; i++) sendBit(1'b1, d);
    selIn = 1'b1;
    tick(2);
    readWord(6'd8, 1'b0, w);
    check("R3 cs low clocks ignored", w, 16'h122A);

    // R2 cs rise aborts a half sent command
    csCycle();
    sendBit(1'b1, d);
    for (int i = 0; i < 4; i++) sendBit(1'b1, d);
    readWord(6'd1, 1'b1, w);
    check("R2 resync after abort", w, 16'h10EC);

    // R4 leading zeros before start bit
    csCycle();
    for (int i = 0; i < 3; i++) sendBit(1'b0, d);
    readWord(6'd2, 1'b0, w);
    check("R4 zeros before start", w, 16'h8139);

    // R5 opcode 11 is idle: following clocks ignored
    csCycle();
    sendCmd(2'b11, 6'd0);
    sendCmd(2'b10, 6'd0);
    shiftData(16'h0000, w);
    check("R5 opcode 11 goes idle", w, 16'h0000);

    // R10 disable blocks write
    extCmd(2'b00);
    writeWord(6'd3, 16'h1234);
    readWord(6'd3, 1'b1, w);
    check("R10 write after disable", w, 16'h0000);

    // R9 fill all, then read without cs cycle
    extCmd(2'b11);
    csCycle();
    sendCmd(2'b00, 6'b010000);
    shiftData(16'hA5C3, w);
    for (int i = 0; i < 64; i++) model[i] = 16'hA5C3;
    readWord(6'd17, 1'b0, w);
    check("R9 fill then read no cs", w, 16'hA5C3);
    readWord(6'd0, 1'b1, w);
    check("R9 fill word 0", w, 16'hA5C3);
    readWord(6'd63, 1'b1, w);
    check("R9 fill word 63", w, 16'hA5C3);

    // random mix, R5 command set against bench model
    for (int n = 0; n < 60; n++) begin
      int          r;
      logic [5:0]  a;
      logic [15:0] v;
      r = $urandom_range(0, 9);
      a = 6'($urandom_range(0, 63));
      v = 16'($urandom);
      if (r < 2) extCmd(2'b11);
      else if (r == 2) extCmd(2'b00);
      else if (r < 6) writeWord(a, v);
      else begin
        readWord(a, 1'b1, w);
        check("R5 random read", w, model[a]);
      end
    end
    for (int i = 0; i < 64; i += 7) begin
      readWord(6'(i), 1'b1, w);
      check("R10 final sweep", w, model[i]);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule